// File: doc/BRIEF.md
# Multiphase Regulator Phase-Mode Controller

This block holds the digital mode logic of a buck regulator controller that can drive up to three phases. When reset is released it captures a static configuration from four strap inputs: a phase-3 strap, a phase-2 strap, a clock-enable pull-up level and a bias-resistor select bit. The configuration it captures is the number of phases, CPU or GPU operation and overshoot reduction. It keeps this configuration until the next reset.

During operation it reads two live inputs, a power-state level and a deep-sleep level. Each passes through a synchroniser. From them the block chooses how many phases stay active and whether the active phase runs in continuous-conduction or diode-emulation mode. It also sets the interleave angle between phases.

It reports an overcurrent scale factor as a numerator and a denominator. The current-limit circuits use this factor to shrink their trip levels in step with the phases that have been shed. All mode outputs come from registers, so a mode change always lands on a single clock edge.

Top module: `phase_mode_ctrl`

## Requirements
- R1: Straps select the phase count. `strap_ph2_hi`=1 gives 1-phase, whatever the phase-3 strap is. Otherwise `strap_ph3_hi`=1 gives 2-phase, and both low gives 3-phase. `phase_en` is a thermometer code: bit 0 is phase 1, and the enabled phases are always the lowest ones (000, 001, 011 or 111).
- R2: `cpu_sel`=1 means CPU operation. In 3- and 2-phase configuration it equals `clken_pullup`. In 1-phase configuration it equals the inverse of `bias_low_sel`, and `clken_pullup` has no effect.
- R3: With `pwr_state`=1 and `deep_sleep`=0, every configured phase is enabled and `diode_emul`=0. The scale is 1/1.
- R4: In 3-phase configuration with `pwr_state`=0 and `deep_sleep`=0, `phase_en`=011 and `diode_emul`=0. The scale is 2/3 and the angle is 180.
- R5: In 2-phase configuration with `pwr_state`=0 and `deep_sleep`=0, `phase_en`=001 and `diode_emul`=0. The scale is 1/2.
- R6: In 3- or 2-phase configuration with `deep_sleep`=1, `phase_en`=001 and `diode_emul`=1. The scale is 1/3, whatever `pwr_state` is.
- R7: In 1-phase configuration, `phase_en`=001 and the scale is 1/1. `pwr_state` has no effect, and `diode_emul` equals `deep_sleep`.
- R8: `overshoot_red_en` is 1 for the low-resistance bias setting (`bias_low_sel`=1) and 0 for the high-resistance setting.
- R9: `interleave_deg` is 120 with three phases active, 180 with two and 0 with one.
- R10: Straps are captured on the first clock edge after reset is released. Later strap changes have no effect until the next reset.
- R11: A change on `pwr_state` or `deep_sleep` reaches the mode outputs on exactly the third rising edge after it. The outputs move straight from the old mode to the new one, and they hold steady while the synchronised inputs hold steady.
- R12: During reset, `phase_en`=000, `diode_emul`=0, `interleave_deg`=0, the scale is 1/1 and `overshoot_red_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_ph3_hi | input | 1 | Phase-3 strap; high removes phase 3 |
| strap_ph2_hi | input | 1 | Phase-2 strap; high forces 1-phase |
| clken_pullup | input | 1 | Clock-enable level; 1 = pulled up (CPU in 3/2-phase) |
| bias_low_sel | input | 1 | Bias select; 1 = low-resistance setting |
| pwr_state | input | 1 | Power-state level, asynchronous |
| deep_sleep | input | 1 | Deep-sleep level, asynchronous |
| phase_en | output | 3 | Per-phase enables, bit 0 = phase 1 |
| diode_emul | output | 1 | 1 = diode emulation, 0 = CCM |
| interleave_deg | output | 8 | Phase spacing in degrees |
| oc_scale_num | output | 2 | Overcurrent scale numerator |
| oc_scale_den | output | 2 | Overcurrent scale denominator |
| overshoot_red_en | output | 1 | Overshoot reduction enable |
| cpu_sel | output | 1 | 1 = CPU operation, 0 = GPU |

## Verification
The power-state and deep-sleep levels can change in the same cycle. Their synchronised copies then reach the mode decode on the same edge, and the decode must give deep-sleep priority without passing through an intermediate mode. The bench switches from full 3-phase operation (power-state 1, deep-sleep 0) to power-state 0 with deep-sleep 1 on a single falling edge. It samples the outputs after each of the next three edges: the old mode must hold on the first two samples and the diode-emulation single-phase mode must appear on the third. A strap change during live mode operation is also checked, to show that strap capture and mode updates do not interfere.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int PH_MAX  = 3;
  localparam int ANGLE_W = 8;
  localparam int SCALE_W = 2;

  typedef enum logic [1:0] {
    CFG_3PH = 2'd0,
    CFG_2PH = 2'd1,
    CFG_1PH = 2'd2
  } ph_cfg_e;

  typedef struct packed {
    ph_cfg_e ph;
    logic    cpu;
    logic    ovr;
  } strap_cfg_t;

  typedef struct packed {
    logic [PH_MAX-1:0]  en;
    logic               de;
    logic [ANGLE_W-1:0] angle;
    logic [SCALE_W-1:0] num;
    logic [SCALE_W-1:0] den;
  } mode_t;

  localparam strap_cfg_t CFG_RESET = '{ph: CFG_3PH, cpu: 1'b0, ovr: 1'b0};

  localparam mode_t MODE_IDLE = '{en: '0, de: 1'b0, angle: '0,
                                  num: SCALE_W'(1), den: SCALE_W'(1)};

  // Strap interpretation: the phase-2 strap dominates the phase-3 strap.
  function automatic strap_cfg_t decode_straps(input logic ph3_hi, input logic ph2_hi,
                                               input logic clken_pu, input logic bias_low);
    strap_cfg_t c;
    if (ph2_hi)      c.ph = CFG_1PH;
    else if (ph3_hi) c.ph = CFG_2PH;
    else             c.ph = CFG_3PH;
    c.cpu = (c.ph == CFG_1PH) ? ~bias_low : clken_pu;
    c.ovr = bias_low;
    return c;
  endfunction

  function automatic int cfg_count(input ph_cfg_e p);
    case (p)
      CFG_3PH: return 3;
      CFG_2PH: return 2;
      default: return 1;
    endcase
  endfunction

  // Phases left running for a given power state.
  function automatic int active_count(input ph_cfg_e p, input logic psi_hi, input logic dslp);
    int full;
    full = cfg_count(p);
    if (dslp)     return 1;
    if (psi_hi)   return full;
    if (full > 1) return full - 1;
    return 1;
  endfunction

  function automatic logic [ANGLE_W-1:0] angle_for(input int n);
    case (n)
      3:       return ANGLE_W'(120);
      2:       return ANGLE_W'(180);
      default: return '0;
    endcase
  endfunction

  function automatic mode_t mode_for(input ph_cfg_e p, input logic psi_hi, input logic dslp);
    mode_t m;
    int full;
    int act;
    full = cfg_count(p);
    act  = active_count(p, psi_hi, dslp);
    for (int i = 0; i < PH_MAX; i++) m.en[i] = (i < act);
    m.de    = dslp;
    m.angle = angle_for(act);
    if (dslp && full > 1) begin
      m.num = SCALE_W'(1);
      m.den = SCALE_W'(3);
    end else if (act == full) begin
      m.num = SCALE_W'(1);
      m.den = SCALE_W'(1);
    end else begin
      m.num = SCALE_W'(act);
      m.den = SCALE_W'(full);
    end
    return m;
  endfunction

endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= chain[g-1];
      end
      AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        chain[g] == $past(chain[g-1])); // R11
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pmc_strap_latch.sv
module pmc_strap_latch
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ph3_hi,
  input  logic       ph2_hi,
  input  logic       clken_pu,
  input  logic       bias_low,
  output strap_cfg_t cfg_q,
  output logic       loaded_q
);

  strap_cfg_t cfg_seen;
  logic       capture_evt;

  assign cfg_seen    = decode_straps(ph3_hi, ph2_hi, clken_pu, bias_low);
  assign capture_evt = !loaded_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= CFG_RESET;
      loaded_q <= 1'b0;
    end else if (capture_evt) begin
      cfg_q    <= cfg_seen;
      loaded_q <= 1'b1;
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_q |=> $stable(cfg_q)); // R10
  AST_LOAD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_q |=> loaded_q); // R10

endmodule

// File: rtl/pmc_mode_reg.sv
module pmc_mode_reg
  import pmc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ph_cfg_e ph,
  input  logic    loaded,
  input  logic    psi_s,
  input  logic    dslp_s,
  output mode_t   mode_q
);

  mode_t mode_next;
  logic  mode_change;

  assign mode_next   = mode_for(ph, psi_s, dslp_s);
  assign mode_change = loaded && (mode_next != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mode_q <= MODE_IDLE;
    else if (mode_change) mode_q <= mode_next;
  end

  AST_DE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.de |-> (mode_q.en == 3'b001)); // R6
  AST_EN_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.en == 3'b000) || (mode_q.en == 3'b001) ||
    (mode_q.en == 3'b011) || (mode_q.en == 3'b111)); // R1
  AST_SCALE_SANE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.den != '0) && (mode_q.num <= mode_q.den)); // R4
  AST_ONEPH_FULLSCALE: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && ph == CFG_1PH) |=> (mode_q.num == mode_q.den)); // R7
  AST_ANGLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(mode_q.en) == 2) |-> (mode_q.angle == 8'd180)); // R9
  AST_STABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && $past(loaded) && $stable({psi_s, dslp_s})) |=> $stable(mode_q)); // R11

endmodule

// File: rtl/phase_mode_ctrl.sv
module phase_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strap_ph3_hi,
  input  logic               strap_ph2_hi,
  input  logic               clken_pullup,
  input  logic               bias_low_sel,
  input  logic               pwr_state,
  input  logic               deep_sleep,
  output logic [PH_MAX-1:0]  phase_en,
  output logic               diode_emul,
  output logic [ANGLE_W-1:0] interleave_deg,
  output logic [SCALE_W-1:0] oc_scale_num,
  output logic [SCALE_W-1:0] oc_scale_den,
  output logic               overshoot_red_en,
  output logic               cpu_sel
);

  strap_cfg_t cfg_q;
  logic       cfg_loaded;
  logic [1:0] live_s;
  mode_t      mode_q;

  pmc_strap_latch i_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .ph3_hi   (strap_ph3_hi),
    .ph2_hi   (strap_ph2_hi),
    .clken_pu (clken_pullup),
    .bias_low (bias_low_sel),
    .cfg_q    (cfg_q),
    .loaded_q (cfg_loaded)
  );

  pmc_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({deep_sleep, pwr_state}),
    .q     (live_s)
  );

  pmc_mode_reg i_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .ph     (cfg_q.ph),
    .loaded (cfg_loaded),
    .psi_s  (live_s[0]),
    .dslp_s (live_s[1]),
    .mode_q (mode_q)
  );

  assign phase_en         = mode_q.en;
  assign diode_emul       = mode_q.de;
  assign interleave_deg   = mode_q.angle;
  assign oc_scale_num     = mode_q.num;
  assign oc_scale_den     = mode_q.den;
  assign overshoot_red_en = cfg_q.ovr;
  assign cpu_sel          = cfg_q.cpu;

endmodule

// File: tb/test_phase_mode_ctrl.sv
module test_phase_mode_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_ph3_hi = 1'b0, strap_ph2_hi = 1'b0, clken_pullup = 1'b0, bias_low_sel = 1'b0;
  logic pwr_state = 1'b1, deep_sleep = 1'b0;
  logic [2:0] phase_en;
  logic       diode_emul;
  logic [7:0] interleave_deg;
  logic [1:0] oc_scale_num, oc_scale_den;
  logic       overshoot_red_en, cpu_sel;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 0;

  always #10 clk = ~clk;

  phase_mode_ctrl i_phase_mode_ctrl (
    .clk(clk), .rst_n(rst_n),
    .strap_ph3_hi(strap_ph3_hi), .strap_ph2_hi(strap_ph2_hi),
    .clken_pullup(clken_pullup), .bias_low_sel(bias_low_sel),
    .pwr_state(pwr_state), .deep_sleep(deep_sleep),
    .phase_en(phase_en), .diode_emul(diode_emul), .interleave_deg(interleave_deg),
    .oc_scale_num(oc_scale_num), .oc_scale_den(oc_scale_den),
    .overshoot_red_en(overshoot_red_en), .cpu_sel(cpu_sel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic p3, input logic p2, input logic ce, input logic bl);
    @(negedge clk);
    rst_n = 1'b0;
    strap_ph3_hi = p3; strap_ph2_hi = p2; clken_pullup = ce; bias_low_sel = bl;
    wait_cyc(2);
    rst_n = 1'b1;
    wait_cyc(4);
  endtask

  // Expected outputs restated from the requirements.
  task automatic check_point(input logic p3, input logic p2, input logic ce, input logic bl,
                             input logic pw, input logic ds);
    int full, act, en, ang, num, den, cpu;
    string tag;
    full = p2 ? 1 : (p3 ? 2 : 3);
    if (ds)       act = 1;
    else if (pw)  act = full;
    else          act = (full == 1) ? 1 : full - 1;
    en  = (1 << act) - 1;
    ang = (act == 3) ? 120 : ((act == 2) ? 180 : 0);
    if (ds && full != 1) begin num = 1; den = 3; end
    else if (act == full) begin num = 1; den = 1; end
    else begin num = act; den = full; end
    cpu = (full == 1) ? int'(!bl) : int'(ce);
    if (ds)             tag = (full == 1) ? "R7" : "R6";
    else if (pw)        tag = "R3";
    else if (full == 3) tag = "R4";
    else if (full == 2) tag = "R5";
    else                tag = "R7";
    chk("R1 phase_en", 32'(phase_en), 32'(en));
    chk({tag, " diode_emul"}, 32'(diode_emul), 32'(ds));
    chk({tag, " scale num"}, 32'(oc_scale_num), 32'(num));
    chk({tag, " scale den"}, 32'(oc_scale_den), 32'(den));
    chk("R9 interleave", 32'(interleave_deg), 32'(ang));
    chk("R2 cpu_sel", 32'(cpu_sel), 32'(cpu));
    chk("R8 overshoot", 32'(overshoot_red_en), 32'(bl));
  endtask

  initial begin
    // R12: outputs while reset is held
    wait_cyc(3);
    chk("R12 phase_en", 32'(phase_en), 0);
    chk("R12 diode_emul", 32'(diode_emul), 0);
    chk("R12 angle", 32'(interleave_deg), 0);
    chk("R12 num", 32'(oc_scale_num), 1);
    chk("R12 den", 32'(oc_scale_den), 1);
    chk("R12 overshoot", 32'(overshoot_red_en), 0);

    // Exhaustive sweep: 16 strap sets x 4 live input pairs
    for (int c = 0; c < 16; c++) begin
      pwr_state = 1'b1; deep_sleep = 1'b0;
      do_reset(c[0], c[1], c[2], c[3]);
      for (int m = 0; m < 4; m++) begin
        pwr_state = m[0]; deep_sleep = m[1];
        wait_cyc(4);
        check_point(c[0], c[1], c[2], c[3], m[0], m[1]);
      end
    end

    // R10: strap change after capture is ignored
    pwr_state = 1'b1; deep_sleep = 1'b0;
    do_reset(1'b0, 1'b0, 1'b1, 1'b0);
    strap_ph3_hi = 1'b1; strap_ph2_hi = 1'b1; clken_pullup = 1'b0; bias_low_sel = 1'b1;
    wait_cyc(4);
    chk("R10 phase_en held", 32'(phase_en), 7);
    chk("R10 cpu_sel held", 32'(cpu_sel), 1);
    chk("R10 overshoot held", 32'(overshoot_red_en), 0);
    do_reset(1'b1, 1'b1, 1'b0, 1'b1);
    chk("R10 new straps after reset", 32'(phase_en), 1);

    // R11: power-state and deep-sleep change on the same edge
    do_reset(1'b0, 1'b0, 1'b1, 1'b0);
    pwr_state = 1'b0; deep_sleep = 1'b1;
    wait_cyc(1);
    chk("R11 old mode after edge 1", 32'({phase_en, diode_emul}), 32'({3'b111, 1'b0}));
    wait_cyc(1);
    chk("R11 old mode after edge 2", 32'({phase_en, diode_emul}), 32'({3'b111, 1'b0}));
    wait_cyc(1);
    chk("R11 new mode after edge 3", 32'({phase_en, diode_emul}), 32'({3'b001, 1'b1}));
    chk("R11 new scale den", 32'(oc_scale_den), 3);

    // R7: power-state toggles in 1-phase configuration leave the outputs unchanged
    pwr_state = 1'b1; deep_sleep = 1'b0;
    do_reset(1'b0, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      pwr_state = ~pwr_state;
      wait_cyc(3);
      chk("R7 psi ignored en", 32'(phase_en), 1);
      chk("R7 psi ignored scale", 32'({oc_scale_num, oc_scale_den}), 32'({2'd1, 2'd1}));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R11 actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule